// File: doc/BRIEF.md
# Variable-Length Microcycle Shift Clock Generator

This block paces a bit-serial microcode engine from one fast master clock. Every microcycle opens with a single load cycle, then gives a run of shift strobes, then a short quiet interval. The number of shift strobes in a microcycle is 1 to 16 and comes from a 4-bit length field of the current microinstruction. A cycle clock output is high through the load cycle and the shift run, and low during the quiet interval. Its high time therefore changes from one microcycle to the next, and the engine never has to run a fixed 16-bit frame.

The shift output is a one-master-cycle enable. Each master cycle in which it is high stands for one bit shift. Refresh logic can hold the engine by asserting a hold request while the cycle clock is low. This extends the quiet interval one master cycle at a time. A hold request raised during a shift run has no effect on that run. A one-cycle completion flag marks the first low cycle of every microcycle.

Top module: `shift_clock_gen`

## Requirements
- R1: While reset is active, and in the first cycle after it, `rck`, `sck`, `load_stb` and `cycle_done` are all 0. The first load cycle comes on the first rising clock edge after reset release at which `hold_req` is 0.
- R2: A load cycle has `load_stb`=1, `rck`=1 and `sck`=0, and lasts exactly one cycle. `len_code` is sampled at the clock edge that ends the load cycle.
- R3: A sampled code n (binary 0 to 15) gives exactly n+1 consecutive cycles of `sck`=1, starting in the cycle right after the load cycle. Code 0 gives one pulse and code 15 gives sixteen.
- R4: `rck` is high for exactly n+2 cycles: the load cycle plus the shift cycles. It falls in the cycle right after the last shift pulse.
- R5: `cycle_done` is 1 for exactly one cycle, the first cycle in which `rck` is low after a microcycle. It is 0 at all other times.
- R6: With `hold_req` at 0, the low phase of `rck` lasts exactly 2 cycles before the next load cycle.
- R7: Each rising edge that falls in the last low cycle and sees `hold_req`=1 adds one more low cycle. The next load cycle follows the first such edge that sees `hold_req`=0.
- R8: `hold_req` has no effect while `rck` is high. The number and timing of shift pulses do not change.
- R9: Changes to `len_code` outside the load cycle do not affect the microcycle in progress.
- R10: `sck` is never 1 while `rck` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mck | input | 1 | Master clock; one shift per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_code | input | 4 | Length code; n gives n+1 shifts |
| hold_req | input | 1 | Request from refresh logic to stretch the low phase |
| sck | output | 1 | Shift strobe, high one cycle per bit |
| rck | output | 1 | Cycle clock, high during load and shift cycles |
| load_stb | output | 1 | High during the load cycle |
| cycle_done | output | 1 | One-cycle pulse in the first low cycle |

## Verification
Two things can fall on the same clock edge. At the end of the low phase, the hold request and the decision to start a new load compete for one edge. At the end of a run, the final shift pulse can coincide with a hold request that the block must ignore. The bench provokes the first case by toggling hold at random during low phases, including on the deciding edge itself. It provokes the second by raising hold exactly while the cycle clock is high and changing the length code on every cycle. A behavioural queue model predicts every output on every cycle and judges each one.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        PH_GAP   = 2'd0,
        PH_LOAD  = 2'd1,
        PH_SHIFT = 2'd2
    } phase_e;

endpackage

// File: rtl/scg_down_counter.sv
module scg_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         dec_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         at_zero
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_s;

    cnt_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (dec_en && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign at_zero = (st_q.cnt == '0);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == $past(load_val)));

    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !load_en && !at_zero) |=> (count == $past(count) - W'(1)));

endmodule

// File: rtl/scg_phase_seq.sv
module scg_phase_seq
    import scg_pkg::*;
#(
    parameter int GAP_CYCLES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cnt_zero,
    input  logic   hold_req,
    output phase_e phase,
    output logic   gap_first,
    output logic   load_en,
    output logic   dec_en
);

    localparam int GAP_W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [GAP_W-1:0] gap;
    } seq_s;

    seq_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_GAP: begin
                if (st_q.gap == GAP_LAST) begin
                    if (!hold_req) begin
                        st_d.phase = PH_LOAD;
                        st_d.gap   = '0;
                    end
                end else begin
                    st_d.gap = st_q.gap + GAP_W'(1);
                end
            end
            PH_LOAD: begin
                st_d.phase = PH_SHIFT;
            end
            PH_SHIFT: begin
                if (cnt_zero) begin
                    st_d.phase = PH_GAP;
                    st_d.gap   = '0;
                end
            end
            default: begin
                st_d.phase = PH_GAP;
                st_d.gap   = GAP_LAST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_GAP;
            st_q.gap   <= GAP_LAST;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase     = st_q.phase;
    assign gap_first = (st_q.phase == PH_GAP) && (st_q.gap == '0);
    assign load_en   = (st_q.phase == PH_LOAD);
    assign dec_en    = (st_q.phase == PH_SHIFT);

    // R2
    load_then_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOAD) |=> (phase == PH_SHIFT));

    // R8
    shift_not_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_SHIFT) && !cnt_zero) |=> (phase == PH_SHIFT));

    // R7
    hold_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_GAP) && (st_q.gap == GAP_LAST) && hold_req) |=> (phase == PH_GAP));

endmodule

// File: rtl/shift_clock_gen.sv
module shift_clock_gen
    import scg_pkg::*;
#(
    parameter int CODE_W     = 4,
    parameter int GAP_CYCLES = 2
) (
    input  logic              mck,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] len_code,
    input  logic              hold_req,
    output logic              sck,
    output logic              rck,
    output logic              load_stb,
    output logic              cycle_done
);

    phase_e            phase;
    logic              gap_first;
    logic              load_en;
    logic              dec_en;
    logic [CODE_W-1:0] count;
    logic              cnt_zero;

    scg_phase_seq #(
        .GAP_CYCLES(GAP_CYCLES)
    ) u_seq (
        .clk      (mck),
        .rst_n    (rst_n),
        .cnt_zero (cnt_zero),
        .hold_req (hold_req),
        .phase    (phase),
        .gap_first(gap_first),
        .load_en  (load_en),
        .dec_en   (dec_en)
    );

    scg_down_counter #(
        .W(CODE_W)
    ) u_cnt (
        .clk     (mck),
        .rst_n   (rst_n),
        .load_en (load_en),
        .dec_en  (dec_en),
        .load_val(len_code),
        .count   (count),
        .at_zero (cnt_zero)
    );

    assign sck        = (phase == PH_SHIFT);
    assign rck        = (phase != PH_GAP);
    assign load_stb   = (phase == PH_LOAD);
    assign cycle_done = gap_first;

    // R10
    sck_in_high_chk: assert property (@(posedge mck) disable iff (!rst_n)
        sck |-> rck);

    // R5
    done_on_fall_chk: assert property (@(posedge mck) disable iff (!rst_n)
        $fell(rck) |-> cycle_done);

    // R5
    done_single_chk: assert property (@(posedge mck) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R6
    low_min_chk: assert property (@(posedge mck) disable iff (!rst_n)
        cycle_done |=> !rck);

    // R2
    load_single_chk: assert property (@(posedge mck) disable iff (!rst_n)
        load_stb |=> (!load_stb && sck));

endmodule

// File: tb/shift_clock_gen_test.sv
module shift_clock_gen_test;

    logic       mck = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] len_code = 4'd0;
    logic       hold_req = 1'b0;
    logic       sck, rck, load_stb, cycle_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 mck = ~mck;

    shift_clock_gen uut (
        .mck       (mck),
        .rst_n     (rst_n),
        .len_code  (len_code),
        .hold_req  (hold_req),
        .sck       (sck),
        .rck       (rck),
        .load_stb  (load_stb),
        .cycle_done(cycle_done)
    );

    // expected tuple {load, rck, sck, done}
    localparam logic [3:0] T_LOW   = 4'b0000;
    localparam logic [3:0] T_LOAD  = 4'b1100;
    localparam logic [3:0] T_SHIFT = 4'b0110;
    localparam logic [3:0] T_DONE  = 4'b0001;

    logic [3:0] cur;
    logic [3:0] q[$];
    string      scen;

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", tag, scen, $time, got, exp);
        end
    endtask

    function automatic logic [3:0] predict(input logic [3:0] c, input logic [3:0] code, input logic hold);
        logic [3:0] n;
        if (c == T_LOAD) begin
            for (int i = 0; i <= int'(code); i++) q.push_back(T_SHIFT);
            q.push_back(T_DONE);
            q.push_back(T_LOW);
        end
        if (q.size() > 0) n = q.pop_front();
        else n = hold ? T_LOW : T_LOAD;
        return n;
    endfunction

    task automatic step(input logic [3:0] code, input logic hold);
        logic [3:0] nxt;
        len_code = code;
        hold_req = hold;
        nxt = predict(cur, code, hold);
        @(posedge mck);
        @(negedge mck);
        chk(load_stb,   nxt[3], "R2 load_stb");
        chk(rck,        nxt[2], "R4 rck");
        chk(sck,        nxt[1], "R3 sck");
        chk(cycle_done, nxt[0], "R5 cycle_done");
        chk(!(sck && !rck), 1'b1, "R10 sck outside rck");
        cur = nxt;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        scen = "R1 reset";
        repeat (3) @(negedge mck);
        chk(rck, 1'b0, "R1 rck");
        chk(sck, 1'b0, "R1 sck");
        chk(load_stb, 1'b0, "R1 load_stb");
        chk(cycle_done, 1'b0, "R1 cycle_done");
        rst_n = 1'b1;
        cur = T_LOW;
        // R1: hold first, then release
        step(4'd3, 1'b1);
        step(4'd3, 1'b1);
        // R3 R6: code sweep, hold low, includes codes 0 and 15
        scen = "R3 R6 sweep";
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < c + 4; k++) step(4'(c), 1'b0);
        end
        // R7: random hold during low phases
        scen = "R7 hold";
        for (int k = 0; k < 800; k++) begin
            logic [3:0] code;
            code = (cur == T_LOAD) ? 4'($urandom_range(0, 15)) : len_code;
            step(code, ($urandom_range(0, 2) != 0));
        end
        // R8: hold asserted exactly while rck is high
        scen = "R8 hold high";
        for (int k = 0; k < 600; k++) begin
            logic [3:0] code;
            code = (cur == T_LOAD) ? 4'($urandom_range(0, 15)) : len_code;
            step(code, cur[2]);
        end
        // R9: code changes on every cycle
        scen = "R9 code churn";
        for (int k = 0; k < 800; k++) begin
            step(4'($urandom), ($urandom_range(0, 3) == 0));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule